// File: doc/BRIEF.md
# Oscillator Start-up Gate and CPU Clock Divider

This block produces the processor clock from the oscillator clock. After reset, or after a wake pulse, it keeps the processor clock low. It waits for a cycle count that depends on the selected oscillator source to run out, and for an external flag that marks the end of a fixed analog settling time. Only after both does it raise a ready flag and let the clock through.

Once released, the oscillator clock either passes straight through or is divided by an even ratio of 2·N. N comes from an 8-bit divisor input, and N = 0 means the clock is not divided. Software may rewrite the divisor at any time. A new divisor is taken up only at the end of the running output period, so the clock never shows a shortened pulse.

A low-power select bit is also kept here. It is cleared by reset, and a request to set it is granted only when the clock rate in force is at or below a configured limit.

Top module: `ckg_top`

## Requirements
- R1: While `rst` is high, `clk_ready`, `cpu_clk` and `lowpower` are all 0.
- R2: Source codes 0, 1 and 2 (the crystal ranges) give a wait of 992 cycles. `clk_ready` is still 0 after the 992nd rising edge following the edge that sampled `rst` or `wake`, and is 1 after the 993rd, provided `analog_done` is 1.
- R3: Source codes 3 to 7 (internal RC, watchdog oscillator, external clock and the unused codes) give a wait of 224 cycles, with the same edge counting as R2.
- R4: When the count has run out but `analog_done` is 0, `clk_ready` stays 0. It becomes 1 on the first rising edge that samples `analog_done` high.
- R5: `clk_ready` stays 1 until the next `rst` or `wake`. A `wake` reloads the count for the source selected at that edge and clears `clk_ready` on that edge.
- R6: `cpu_clk` is 0 from the second edge after `rst` or `wake` until the divider starts again.
- R7: With N ≥ 1, `cpu_clk` is high for N oscillator cycles and then low for N cycles. The first high phase starts on the edge after `clk_ready` rises.
- R8: With N = 0, `cpu_clk` copies the oscillator clock. Its first pulse starts on the edge after `clk_ready` rises.
- R9: A change on `div_n` takes effect only at the end of the low phase of the running period. The running period keeps its old length.
- R10: A switch from N ≥ 1 to N = 0 lengthens the last low phase to N+1 cycles, after which `cpu_clk` copies the oscillator clock.
- R11: A write with `lp_we` = 1 sets `lowpower` to `lp_wdata` on the next edge. A write of 1 is granted only if the divided rate, OSC_KHZ/(2N) or OSC_KHZ when N = 0, is at most LP_MAX_KHZ. Otherwise `lowpower` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high; also starts the wait |
| src_sel | input | 3 | Oscillator source code |
| wake | input | 1 | Wake pulse; restarts the wait |
| analog_done | input | 1 | Analog settling time has elapsed |
| div_n | input | DIV_W | Divisor N; clock rate is divided by 2·N, with 0 meaning no division |
| lp_we | input | 1 | Write strobe for the low-power bit |
| lp_wdata | input | 1 | Value written to the low-power bit |
| cpu_clk | output | 1 | Gated, divided processor clock |
| clk_ready | output | 1 | Start-up wait complete |
| lowpower | output | 1 | Low-power select bit |

## Verification
A wrong start-up count shows at `clk_ready` as a release edge that is early or late against an exact edge count, within one wait after the pulse. A divider whose counter or active divisor is corrupt shows within one output period as a wrong high or low run length on `cpu_clk`. An early change of divisor shows in the very period during which `div_n` was rewritten. A wrong rate limit or a missing reset of the low-power bit shows on the edge after a write or a reset.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic [2:0] {
    SRC_XTAL_LO  = 3'd0,
    SRC_XTAL_MID = 3'd1,
    SRC_XTAL_HI  = 3'd2,
    SRC_RC       = 3'd3,
    SRC_WDOG     = 3'd4,
    SRC_EXT      = 3'd5
  } osc_src_e;

  // Crystal sources need the long settling count.
  function automatic logic src_is_crystal(input logic [2:0] code);
    return code <= 3'(SRC_XTAL_HI);
  endfunction
endpackage

// File: rtl/ckg_startup_timer.sv
module ckg_startup_timer #(
  parameter int XTAL_WAIT  = 992,
  parameter int OTHER_WAIT = 224,
  parameter int CNT_W      = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wake,
  input  logic [2:0] src_sel,
  input  logic       analog_done,
  output logic       ready_o
);
  import ckg_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             ready_q;

  always_comb begin
    load_val = src_is_crystal(src_sel) ? CNT_W'(XTAL_WAIT) : CNT_W'(OTHER_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst || wake) begin
      cnt_q   <= load_val;
      ready_q <= 1'b0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0 && analog_done) ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;

  p_wake_drops_ready_r5: assert property (@(posedge clk) disable iff (rst)
    wake |=> !ready_q);
  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !wake) |=> ready_q);
  p_ready_needs_analog_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(analog_done));
  p_no_release_while_counting_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> !ready_q);
endmodule

// File: rtl/ckg_divider.sv
module ckg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_n,
  output logic             cpu_clk,
  output logic             byp_o,
  output logic [DIV_W-1:0] n_act_o
);
  logic [DIV_W-1:0] n_q;
  logic [DIV_W-1:0] cnt_q;
  logic             q_div;
  logic             byp_q;
  logic             gate_n;
  logic             last_cnt;
  logic             bound;

  // End of a phase; a period ends when the low phase ends (or every cycle in bypass).
  always_comb begin
    last_cnt = (cnt_q == n_q - 1'b1);
    bound    = byp_q | (!q_div & last_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) n_q <= '0;
    else if (run && bound) n_q <= div_n;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      q_div <= 1'b0;
      cnt_q <= '0;
      byp_q <= 1'b1;
    end else if (bound) begin
      byp_q <= (div_n == '0);
      q_div <= (div_n != '0);
      cnt_q <= '0;
    end else if (last_cnt) begin
      cnt_q <= '0;
      q_div <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Bypass enable changes only while the oscillator clock is low.
  always_ff @(negedge clk) begin
    if (rst) gate_n <= 1'b0;
    else     gate_n <= run & byp_q;
  end

  assign cpu_clk = (clk & gate_n) | q_div;
  assign byp_o   = byp_q;
  assign n_act_o = n_q;

  p_hold_divisor_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !bound) |=> $stable(n_q));
  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !q_div);
  p_modes_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    byp_q |-> !q_div);
endmodule

// File: rtl/ckg_lowpower.sv
module ckg_lowpower #(
  parameter int DIV_W      = 8,
  parameter int OSC_KHZ    = 18000,
  parameter int LP_MAX_KHZ = 8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             wdata,
  input  logic             byp,
  input  logic [DIV_W-1:0] n_act,
  output logic             lp_o
);
  logic [31:0] lim_khz;
  logic        allowed;
  logic        lp_q;

  always_comb begin
    lim_khz = 32'(LP_MAX_KHZ) * 32'({n_act, 1'b0});
    allowed = byp ? (32'(OSC_KHZ) <= 32'(LP_MAX_KHZ)) : (32'(OSC_KHZ) <= lim_khz);
  end

  always_ff @(posedge clk) begin
    if (rst)     lp_q <= 1'b0;
    else if (we) lp_q <= wdata & allowed;
  end

  assign lp_o = lp_q;

  p_lp_guard_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(lp_q) |-> $past(we && allowed));
  p_lp_reset_r11: assert property (@(posedge clk)
    rst |=> !lp_q);
endmodule

// File: rtl/ckg_top.sv
module ckg_top #(
  parameter int XTAL_WAIT  = 992,
  parameter int OTHER_WAIT = 224,
  parameter int DIV_W      = 8,
  parameter int OSC_KHZ    = 18000,
  parameter int LP_MAX_KHZ = 8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       src_sel,
  input  logic             wake,
  input  logic             analog_done,
  input  logic [DIV_W-1:0] div_n,
  input  logic             lp_we,
  input  logic             lp_wdata,
  output logic             cpu_clk,
  output logic             clk_ready,
  output logic             lowpower
);
  localparam int MAX_WAIT = (XTAL_WAIT > OTHER_WAIT) ? XTAL_WAIT : OTHER_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic             ready;
  logic             byp;
  logic [DIV_W-1:0] n_act;

  ckg_startup_timer #(
    .XTAL_WAIT(XTAL_WAIT), .OTHER_WAIT(OTHER_WAIT), .CNT_W(CNT_W)
  ) i_timer (
    .clk(clk), .rst(rst), .wake(wake), .src_sel(src_sel),
    .analog_done(analog_done), .ready_o(ready)
  );

  ckg_divider #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst(rst), .run(ready), .div_n(div_n),
    .cpu_clk(cpu_clk), .byp_o(byp), .n_act_o(n_act)
  );

  ckg_lowpower #(
    .DIV_W(DIV_W), .OSC_KHZ(OSC_KHZ), .LP_MAX_KHZ(LP_MAX_KHZ)
  ) i_lp (
    .clk(clk), .rst(rst), .we(lp_we), .wdata(lp_wdata),
    .byp(byp), .n_act(n_act), .lp_o(lowpower)
  );

  assign clk_ready = ready;

  p_gated_until_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (!ready && !$past(ready)) |-> !cpu_clk);
endmodule

// File: tb/test_ckg_top.sv
module test_ckg_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] src_sel = 3'd0;
  logic       wake = 1'b0;
  logic       analog_done = 1'b1;
  logic [7:0] div_n = 8'd0;
  logic       lp_we = 1'b0;
  logic       lp_wdata = 1'b0;
  logic       cpu_clk, clk_ready, lowpower;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ckg_top i_ckg_top (
    .clk(clk), .rst(rst), .src_sel(src_sel), .wake(wake),
    .analog_done(analog_done), .div_n(div_n), .lp_we(lp_we),
    .lp_wdata(lp_wdata), .cpu_clk(cpu_clk), .clk_ready(clk_ready),
    .lowpower(lowpower)
  );

  // Vector: {source code, divisor N, expected wait}
  localparam int NVEC = 7;
  localparam logic [20:0] VEC [NVEC] = '{
    {3'd0, 8'd1, 10'd992}, {3'd1, 8'd4, 10'd992}, {3'd2, 8'd0, 10'd992},
    {3'd3, 8'd2, 10'd224}, {3'd4, 8'd0, 10'd224}, {3'd5, 8'd7, 10'd224},
    {3'd7, 8'd3, 10'd224}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at posedge+2 after the edge that sampled rst/wake.
  task automatic wait_ready(input int w, input string req);
    @(posedge clk); #2;
    chk("R6 clock low during wait", int'(cpu_clk), 0);
    repeat (w - 1) @(posedge clk);
    #2;
    chk({req, " not ready at last count"}, int'(clk_ready), 0);
    chk("R6 clock low at last count", int'(cpu_clk), 0);
    @(posedge clk); #2;
    chk({req, " ready after count"}, int'(clk_ready), 1);
  endtask

  // Expects cpu_clk == val at posedge+2 for len cycles.
  task automatic expect_run(input int val, input int len, input string req);
    int errs = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #2;
      if (int'(cpu_clk) != val) errs++;
    end
    chk(req, errs, 0);
  endtask

  task automatic pulse_wake(input logic [2:0] s, input logic [7:0] n);
    @(negedge clk);
    src_sel = s; div_n = n; wake = 1'b1;
    @(posedge clk); #2;
    wake = 1'b0;
  endtask

  task automatic lp_write(input logic v);
    @(negedge clk);
    lp_we = 1'b1; lp_wdata = v;
    @(posedge clk); #2;
    lp_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R1 ready in reset", int'(clk_ready), 0);
    chk("R1 cpu_clk in reset", int'(cpu_clk), 0);
    chk("R1 lowpower in reset", int'(lowpower), 0);
    rst = 1'b0;
    wait_ready(992, "R2 from reset");
    @(posedge clk); #2;
    chk("R8 bypass high phase", int'(cpu_clk), 1);
    @(negedge clk); #2;
    chk("R8 bypass low phase", int'(cpu_clk), 0);

    // Vector table: wait length per source, then output period
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] s;
      logic [7:0] n;
      int w;
      s = VEC[v][20:18];
      n = VEC[v][17:10];
      w = int'(VEC[v][9:0]);
      pulse_wake(s, n);
      wait_ready(w, (s < 3) ? "R2" : "R3");
      chk("R5 ready sticky", int'(clk_ready), 1);
      if (n == 0) begin
        for (int k = 0; k < 3; k++) begin
          @(posedge clk); #2;
          chk("R8 follows oscillator high", int'(cpu_clk), 1);
          @(negedge clk); #2;
          chk("R8 follows oscillator low", int'(cpu_clk), 0);
        end
      end else begin
        expect_run(1, int'(n), "R7 first high phase");
        expect_run(0, int'(n), "R7 first low phase");
        expect_run(1, int'(n), "R7 second high phase");
        expect_run(0, int'(n), "R7 second low phase");
      end
    end

    // R4: analog flag holds the release
    @(negedge clk); analog_done = 1'b0;
    pulse_wake(3'd5, 8'd2);
    repeat (240) @(posedge clk);
    #2;
    chk("R4 held by analog flag", int'(clk_ready), 0);
    chk("R6 held clock low", int'(cpu_clk), 0);
    @(negedge clk); analog_done = 1'b1;
    @(posedge clk); #2;
    chk("R4 release on analog flag", int'(clk_ready), 1);

    // R9: divisor change mid-period waits for period end
    pulse_wake(3'd4, 8'd3);
    wait_ready(224, "R3");
    expect_run(1, 1, "R9 first high sample");
    div_n = 8'd5;
    expect_run(1, 2, "R9 old high length kept");
    expect_run(0, 3, "R9 old low length kept");
    expect_run(1, 5, "R9 new high length");
    expect_run(0, 5, "R9 new low length");

    // R10: switch to no division
    div_n = 8'd2;
    expect_run(1, 2, "R9 high after second change");
    div_n = 8'd0;
    expect_run(0, 3, "R10 stretched low phase");
    expect_run(1, 1, "R10 follows oscillator");
    @(negedge clk); #2;
    chk("R10 oscillator low phase", int'(cpu_clk), 0);

    // R11: low-power bit guard (18000 kHz oscillator, 8000 kHz limit)
    lp_write(1'b1);
    chk("R11 refused at undivided rate", int'(lowpower), 0);
    @(negedge clk); div_n = 8'd3;
    repeat (4) @(posedge clk);
    lp_write(1'b1);
    chk("R11 granted at N=3", int'(lowpower), 1);
    @(negedge clk); div_n = 8'd1;
    repeat (10) @(posedge clk);
    lp_write(1'b1);
    chk("R11 refused at N=1", int'(lowpower), 0);
    @(negedge clk); div_n = 8'd2;
    repeat (6) @(posedge clk);
    lp_write(1'b1);
    chk("R11 granted at N=2", int'(lowpower), 1);
    lp_write(1'b0);
    chk("R11 write zero clears", int'(lowpower), 0);
    lp_write(1'b1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    chk("R1 reset clears lowpower", int'(lowpower), 0);
    chk("R1 reset clears ready", int'(clk_ready), 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule